// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller

This block drives a successive-approximation analog-to-digital converter that sits behind a small input multiplexer. Software programs a settling delay and then writes the control word with a channel number and the power bit set. The block then routes that channel to the converter and waits the programmed number of clock periods so the analog front end can settle. After that it searches for the input level one bit per clock, from the most significant bit down, using an external comparator. When the search ends it stores the result and raises a completion flag. An interrupt line follows that flag when interrupts are enabled.

The register window has four 32-bit words, selected by `bus_addr[3:2]`: the result at offset 0x0, the status at 0x4, the control word at 0x8 and the settling delay at 0xC. Reads are combinational. A write takes effect on the clock edge where `bus_we` is high. Writing the control word with the power bit clear powers the converter down and abandons any conversion in progress. A write with the power bit set during a conversion starts over with the newly written channel.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the result, status and control words read 0, the delay word reads 8, and `irq`, `dac_code` and `ch_sel` are 0.
- R2: A control write with bit 3 set and a channel field (bits [2:0]) below NUM_CH (6) starts a conversion, and `ch_sel` shows that channel from the next cycle on.
- R3: The delay word at 0xC reads back what was written. The completion flag appears exactly DELAY + RES_W clock edges after the edge that accepted the starting write.
- R4: With an ideal comparator (`cmp_ge` = input ≥ `dac_code`), the result word at 0x0 holds the input code in bits [9:0], and bits [31:10] read 0.
- R5: Control bit 6 sets when a conversion completes. Any accepted control write clears it.
- R6: `irq` equals control bit 6 AND control bit 5 (interrupt enable).
- R7: Status bit 0 reads 1 during the settling and conversion phases, and 0 when idle or finished.
- R8: An accepted control write with bit 3 clear stops any settling or conversion at once. No completion follows, and the result word keeps its previous value.
- R9: A control write whose channel field is NUM_CH or above is ignored: the control word is unchanged, no conversion starts, and a running conversion continues with unchanged timing.
- R10: A start write accepted while a conversion runs restarts the settling phase on the new channel, and completion timing counts from that write.
- R11: `dac_code` is 0 outside the conversion phase. In the first conversion cycle it equals 2^(RES_W-1) (512), and each later cycle tests the next lower bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ch_sel | output | 3 | Analog multiplexer channel |
| dac_code | output | 10 | Trial code for the comparison DAC |
| cmp_ge | input | 1 | Comparator: input is at or above `dac_code` |
| irq | output | 1 | Completion interrupt |

## Verification
The search is swept over every one of the 1024 input codes, each on a rotating channel with a rotating settling delay of 0, 1, 2 or 8. This separates errors in bit order and keep/drop decisions from off-by-one errors in the delay count, and it exposes a channel routing fault as a wrong result. The zero-delay runs show whether the start edge loads the search correctly. Separate runs then abort during settling and during conversion, issue writes with out-of-range channels both while idle and in mid-conversion, and restart a running conversion on another channel. These runs tell a true abort from a late completion, an ignored write from one that disturbs timing, and a restart from a continuation of the old search.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

    localparam int CH_W  = 3;
    localparam int BUS_W = 32;

    // word select from bus_addr[3:2]
    localparam logic [1:0] WSEL_RESULT = 2'd0;
    localparam logic [1:0] WSEL_STATUS = 2'd1;
    localparam logic [1:0] WSEL_CTRL   = 2'd2;
    localparam logic [1:0] WSEL_DELAY  = 2'd3;

    // control word bit positions, decoded by software
    localparam int CTL_PWR  = 3;
    localparam int CTL_IEN  = 5;
    localparam int CTL_DONE = 6;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_SEARCH
    } phase_e;

    typedef struct packed {
        logic            done;
        logic            ien;
        logic            pwr;
        logic [CH_W-1:0] chan;
    } ctrl_t;

    function automatic logic chan_in_range(input logic [CH_W-1:0] ch, input int count);
        return int'(ch) < count;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w                 = '0;
        w[CH_W-1:0]       = c.chan;
        w[CTL_PWR]        = c.pwr;
        w[CTL_IEN]        = c.ien;
        w[CTL_DONE]       = c.done;
        return w;
    endfunction

endpackage

// File: rtl/sar_regfile.sv
`timescale 1ns/1ps
module sar_regfile
    import sar_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int NUM_CH    = 6,
    parameter int DLY_W     = 16,
    parameter int DLY_RESET = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       bus_addr,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             busy,
    input  logic             done_set,
    input  logic [RES_W-1:0] result,
    output ctrl_t            ctrl_q,
    output logic [DLY_W-1:0] dly_q,
    output logic             start,
    output logic             abort
);

    logic [1:0]       wsel;
    logic             ctrl_wr;
    logic             ctrl_ok;
    logic [RES_W-1:0] data_q;

    assign wsel    = bus_addr[3:2];
    assign ctrl_wr = bus_we && (wsel == WSEL_CTRL);
    assign ctrl_ok = ctrl_wr && chan_in_range(bus_wdata[CH_W-1:0], NUM_CH);
    assign start   = ctrl_ok && bus_wdata[CTL_PWR];
    assign abort   = ctrl_ok && !bus_wdata[CTL_PWR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
            dly_q  <= DLY_W'(DLY_RESET);
        end else begin
            if (ctrl_ok) begin
                ctrl_q.chan <= bus_wdata[CH_W-1:0];
                ctrl_q.pwr  <= bus_wdata[CTL_PWR];
                ctrl_q.ien  <= bus_wdata[CTL_IEN];
                ctrl_q.done <= 1'b0;
            end else if (done_set) begin
                ctrl_q.done <= 1'b1;
            end
            if (done_set && !ctrl_ok) begin
                data_q <= result;
            end
            if (bus_we && (wsel == WSEL_DELAY)) begin
                dly_q <= bus_wdata[DLY_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (wsel)
            WSEL_RESULT: bus_rdata[RES_W-1:0] = data_q;
            WSEL_STATUS: bus_rdata[0]         = busy;
            WSEL_CTRL:   bus_rdata            = ctrl_to_word(ctrl_q);
            WSEL_DELAY:  bus_rdata[DLY_W-1:0] = dly_q;
            default:     bus_rdata            = '0;
        endcase
    end

endmodule

// File: rtl/sar_sequencer.sv
`timescale 1ns/1ps
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [DLY_W-1:0] dly,
    input  logic             last_bit,
    output phase_e           phase,
    output logic             load,
    output logic             done_set,
    output logic [DLY_W-1:0] dly_cnt
);

    localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

    always_comb begin
        load = 1'b0;
        if (start) begin
            load = (dly == '0);
        end else if (!abort && phase == PH_SETTLE && dly_cnt == '0) begin
            load = 1'b1;
        end
    end

    assign done_set = (phase == PH_SEARCH) && last_bit && !start && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            dly_cnt <= '0;
        end else if (abort) begin
            phase   <= PH_IDLE;
            dly_cnt <= '0;
        end else if (start) begin
            if (dly == '0) begin
                phase   <= PH_SEARCH;
                dly_cnt <= '0;
            end else begin
                phase   <= PH_SETTLE;
                dly_cnt <= dly - ONE;
            end
        end else begin
            unique case (phase)
                PH_SETTLE: begin
                    if (dly_cnt == '0) phase <= PH_SEARCH;
                    else               dly_cnt <= dly_cnt - ONE;
                end
                PH_SEARCH: begin
                    if (last_bit) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_approx.sv
`timescale 1ns/1ps
module sar_approx #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             active,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] dac_code,
    output logic             last_bit,
    output logic [RES_W-1:0] result
);

    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] probe_q;   // one-hot pointer to the bit on trial
    logic [RES_W-1:0] trial;

    assign trial    = acc_q | probe_q;
    assign result   = cmp_ge ? trial : acc_q;
    assign last_bit = active && probe_q[0];
    assign dac_code = active ? trial : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            probe_q <= '0;
        end else if (load) begin
            acc_q   <= '0;
            probe_q <= TOP_BIT;
        end else if (active) begin
            acc_q   <= result;
            probe_q <= probe_q >> 1;
        end
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int NUM_CH    = 6,
    parameter int DLY_W     = 16,
    parameter int DLY_RESET = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       bus_addr,
    input  logic             bus_we,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [2:0]       ch_sel,
    output logic [RES_W-1:0] dac_code,
    input  logic             cmp_ge,
    output logic             irq
);

    ctrl_t            ctrl_q;
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] dly_cnt;
    logic             start;
    logic             abort;
    logic             load;
    logic             done_set;
    logic             last_bit;
    logic [RES_W-1:0] result;
    phase_e           phase;
    logic             busy;
    logic             in_conv;
    logic             done_flag;

    assign busy      = (phase != PH_IDLE);
    assign in_conv   = (phase == PH_SEARCH);
    assign done_flag = ctrl_q.done;
    assign ch_sel    = ctrl_q.chan;
    assign irq       = done_flag & ctrl_q.ien;

    sar_regfile #(
        .RES_W(RES_W), .NUM_CH(NUM_CH), .DLY_W(DLY_W), .DLY_RESET(DLY_RESET)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done_set(done_set), .result(result),
        .ctrl_q(ctrl_q), .dly_q(dly_q), .start(start), .abort(abort)
    );

    sar_sequencer #(.DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .dly(dly_q),
        .last_bit(last_bit), .phase(phase), .load(load), .done_set(done_set),
        .dly_cnt(dly_cnt)
    );

    sar_approx #(.RES_W(RES_W)) u_sar (
        .clk(clk), .rst(rst), .load(load), .active(in_conv), .cmp_ge(cmp_ge),
        .dac_code(dac_code), .last_bit(last_bit), .result(result)
    );

endmodule

// File: rtl/sar_adc_chk.sv
`timescale 1ns/1ps
module sar_adc_chk #(
    parameter int RES_W  = 10,
    parameter int NUM_CH = 6,
    parameter int DLY_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       bus_addr,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input logic [2:0]       ch_sel,
    input logic [RES_W-1:0] dac_code,
    input logic             irq,
    input logic             busy,
    input logic             in_conv,
    input logic             done_q,
    input logic [DLY_W-1:0] cnt
);

    logic ctrl_wr;
    logic ch_ok;
    assign ctrl_wr = bus_we && (bus_addr[3:2] == 2'd2);
    assign ch_ok   = int'(bus_wdata[2:0]) < NUM_CH;

    assert_chan_range_R9: assert property (@(posedge clk) disable iff (rst)
        int'(ch_sel) < NUM_CH);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ch_ok && bus_wdata[3]) |=> (busy && !done_q));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ch_ok && !bus_wdata[3]) |=> (!busy && !done_q));

    assert_settle_count_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !in_conv && !ctrl_wr && cnt != '0) |=>
            (cnt == $past(cnt) - {{(DLY_W-1){1'b0}}, 1'b1}));

    assert_irq_idle_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

    assert_dac_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !in_conv |-> (dac_code == '0));

    assert_first_trial_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(in_conv) |-> (dac_code == {1'b1, {(RES_W-1){1'b0}}}));

endmodule

bind sar_adc_ctrl sar_adc_chk #(.RES_W(RES_W), .NUM_CH(NUM_CH), .DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .ch_sel(ch_sel), .dac_code(dac_code), .irq(irq), .busy(busy), .in_conv(in_conv),
    .done_q(done_flag), .cnt(dly_cnt)
);

// File: tb/test_sar_adc_ctrl.sv
`timescale 1ns/1ps
module test_sar_adc_ctrl;

    localparam int RES_W = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  ch_sel;
    logic [RES_W-1:0] dac;
    logic        cmp;
    logic        irq;
    int          vin [8];
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    assign cmp = vin[ch_sel] >= int'(dac);

    sar_adc_ctrl i_sar_adc_ctrl (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .ch_sel(ch_sel), .dac_code(dac), .cmp_ge(cmp), .irq(irq)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    // counts negedges from the current one until control bit 6 reads 1
    task automatic wait_done(input int start_n, output int n);
        logic [31:0] r;
        n = start_n;
        rd(4'h8, r);
        while (!r[6] && n < 3000) begin
            @(negedge clk);
            n++;
            rd(4'h8, r);
        end
    endtask

    task automatic run_conv(input int ch, input int code, input int dly, input bit ien);
        logic [31:0] r;
        int n;
        bit seen;
        vin[ch] = code;
        wr(4'hC, dly);
        wr(4'h8, (ien << 5) | 8 | ch);
        rd(4'h4, r);
        chk("R7", "busy after start", r[0], 1);
        chk("R2", "ch_sel", ch_sel, ch);
        chk("R5", "done cleared by start", irq, 0);
        n = 0; seen = 0;
        while (!seen && n < 3000) begin
            if (n == dly) chk("R11", "first trial code", dac, 512);
            else if (n < dly) chk("R11", "dac quiet while settling", dac, 0);
            @(negedge clk);
            n++;
            rd(4'h8, r);
            seen = r[6];
        end
        chk("R3", "latency", n, dly + RES_W);
        rd(4'h0, r);
        chk("R4", "result", r, code);
        rd(4'h4, r);
        chk("R7", "busy after done", r[0], 0);
        chk("R6", "irq", irq, ien);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] r;
        int n;
        for (int i = 0; i < 8; i++) vin[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, r); chk("R1", "result word", r, 0);
        rd(4'h4, r); chk("R1", "status word", r, 0);
        rd(4'h8, r); chk("R1", "control word", r, 0);
        rd(4'hC, r); chk("R1", "delay word", r, 8);
        chk("R1", "irq", irq, 0);
        chk("R1", "dac_code", dac, 0);
        chk("R1", "ch_sel", ch_sel, 0);

        // R3 delay readback
        wr(4'hC, 32'd3);
        rd(4'hC, r); chk("R3", "delay readback", r, 3);

        // R4 full sweep of input codes
        for (int code = 0; code < 1024; code++) begin
            int d;
            d = (code % 4 == 3) ? 8 : code % 4;
            run_conv(code % 6, code, d, (code >> 1) & 1);
        end

        // R5/R8 abort write clears done, keeps result
        wr(4'h8, 32'h20);
        rd(4'h8, r); chk("R5", "done cleared by write", r[6], 0);
        chk("R6", "irq after clear", irq, 0);
        rd(4'h0, r); chk("R8", "result kept", r, 1023);

        // R8 abort during conversion
        vin[2] = 300;
        wr(4'hC, 32'd8);
        wr(4'h8, 32'h0A);
        repeat (12) @(negedge clk);
        wr(4'h8, 32'h0);
        rd(4'h4, r); chk("R8", "busy after abort in search", r[0], 0);
        chk("R8", "dac after abort", dac, 0);
        repeat (40) @(negedge clk);
        rd(4'h8, r); chk("R8", "no done after abort", r[6], 0);
        rd(4'h0, r); chk("R8", "result unchanged", r, 1023);

        // R8 abort during settling
        wr(4'h8, 32'h0B);
        repeat (3) @(negedge clk);
        wr(4'h8, 32'h0);
        rd(4'h4, r); chk("R8", "busy after abort in settle", r[0], 0);
        repeat (40) @(negedge clk);
        rd(4'h8, r); chk("R8", "no done after settle abort", r[6], 0);

        // R9 out-of-range channel while idle
        wr(4'h8, 32'h2E);
        rd(4'h8, r); chk("R9", "ctrl unchanged ch6", r, 0);
        rd(4'h4, r); chk("R9", "no start ch6", r[0], 0);
        wr(4'h8, 32'h0F);
        rd(4'h8, r); chk("R9", "ctrl unchanged ch7", r, 0);
        repeat (40) @(negedge clk);
        rd(4'h8, r); chk("R9", "no done ch7", r[6], 0);
        rd(4'h0, r); chk("R9", "result unchanged", r, 1023);

        // R9 out-of-range write during a running conversion
        vin[4] = 640;
        wr(4'h8, 32'h0C);
        repeat (4) @(negedge clk);
        addr = 4'h8; wdata = 32'h0F; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        wait_done(5, n);
        chk("R9", "latency with ignored write", n, 8 + RES_W);
        chk("R9", "ch_sel kept", ch_sel, 4);
        rd(4'h0, r); chk("R9", "result with ignored write", r, 640);

        // R10 restart mid-conversion on another channel
        vin[1] = 100; vin[2] = 777;
        wr(4'hC, 32'd4);
        wr(4'h8, 32'h09);
        repeat (8) @(negedge clk);
        wr(4'h8, 32'h2A);
        chk("R10", "ch_sel after restart", ch_sel, 2);
        rd(4'h8, r); chk("R10", "done clear after restart", r[6], 0);
        wait_done(0, n);
        chk("R10", "latency from restart", n, 4 + RES_W);
        rd(4'h0, r); chk("R10", "restart result", r, 777);
        chk("R6", "irq after restart", irq, 1);

        summary();
    end

endmodule